// File: doc/BRIEF.md
# Slot-Table Virtual Channel Arbiter

This block chooses which virtual channel may send next on the egress side of a packet link port. Requests arrive as one pending bit per traffic class (eight classes, 0 lowest priority, 7 highest). A software-loaded class map assigns each class to a virtual channel, and a channel counts as pending when at least one of its classes is requesting. A slot table, also loaded by software, lists the channel that owns each time slot. The arbiter walks this table in order, one slot per clock, and wraps back to the start without end.

When the owner of the current slot has nothing pending, the arbiter looks a few entries further on in the same cycle and grants the first owner that is pending. Short gaps in the table therefore cost no idle cycles. The grant names one channel, one-hot, and also names the highest requesting class mapped to it. Writes to the table and the map take effect only while the arbiter is disabled. Enabling it restarts the walk at entry 0. A class mapped to an unusable channel is flagged, and its requests are never granted.

Top module: `vc_slot_arbiter`

## Requirements
- R1: After reset the grant is idle, every table entry holds the empty code 3, every class maps to channel 0, and the slot pointer is at entry 0.
- R2: A config write with `cfg_sel`=0 stores `cfg_data` into table entry `cfg_addr`. A write with `cfg_sel`=1 stores `cfg_data` as the channel of class `cfg_addr[2:0]`. Writes made while `arb_en` is 1 are ignored.
- R3: When every channel is pending, grants follow the table entries in ascending order. After the last entry of the selected length, the walk continues at entry 0.
- R4: `tbl_len` selects the active table length: 0 gives 32 entries, 1 gives 64, and 2 or 3 give 128. Entries at or beyond the active length never own a slot.
- R5: A 7-entry schedule of channels 2,1,1,2,0,0,0 (repeated four times in a 32-entry table, with the last four entries empty) gives, under full load, the grant order 2,1,1,2,0,0,0 repeated with no idle cycle. Channel 2 thus gets 2 of every 7 grants.
- R6: An entry is skipped in the same cycle when it is empty, names a channel of index NUM_VC or above, or names a channel with nothing pending. Within a window of LOOK entries starting at the pointer, the first usable entry is granted and the pointer moves just past it. If no entry in the window is usable, there is no grant that cycle and the pointer advances by LOOK.
- R7: When no channel is pending, no grant is issued and the pointer holds.
- R8: `gnt_vc` is one-hot or zero, `gnt_vld` is set exactly when a grant is issued, and `gnt_tc` is the highest requesting class mapped to the granted channel (0 when there is no grant).
- R9: While `arb_en` is 0 no grant is issued. The first slot after enabling is entry 0.
- R10: `map_err[c]` is 1 when class c maps to a channel of index NUM_VC or above, or to a channel whose `vc_en` bit is 0. Such a class is never granted.
- R11: Several classes may share one channel, and that channel is pending when any of them requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbiter enable; config writes only while low |
| vc_en | input | NUM_VC | Per-channel enable |
| tbl_len | input | 2 | Active table length select |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 1 | 0 = slot table, 1 = class map |
| cfg_addr | input | 7 | Table entry or class index |
| cfg_data | input | 2 | Channel index (3 = empty) |
| tc_req | input | 8 | Pending request per traffic class |
| gnt_vld | output | 1 | A grant is issued this cycle |
| gnt_vc | output | NUM_VC | One-hot granted channel |
| gnt_tc | output | 3 | Class served by the grant |
| map_err | output | 8 | Per-class mapping error |

## Verification
Skipping and granting can happen in the same cycle. An entry whose owner is idle is passed over, and a later entry in the lookahead window is granted at once. This is provoked by requesting only channel 0 against the 2,1,1,2,0,0,0 schedule, which must give a channel-0 grant on every cycle. It is also provoked with a table that is mostly empty, where grants must land exactly on the cycles predicted by advancing the pointer LOOK entries at a time. A second pairing, a config write arriving while the arbiter is enabled, is judged by the grant order seen after the next enable.

// File: rtl/vc_slot_arbiter.sv
module vc_slot_arbiter #(
  parameter int NUM_VC      = 3,
  parameter int TABLE_DEPTH = 128,
  parameter int LOOK        = 8,
  localparam int PW = $clog2(TABLE_DEPTH),
  localparam int VW = 2,
  localparam int NTC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_en,
  input  logic [NUM_VC-1:0] vc_en,
  input  logic [1:0]        tbl_len,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [PW-1:0]     cfg_addr,
  input  logic [VW-1:0]     cfg_data,
  input  logic [NTC-1:0]    tc_req,
  output logic              gnt_vld,
  output logic [NUM_VC-1:0] gnt_vc,
  output logic [2:0]        gnt_tc,
  output logic [NTC-1:0]    map_err
);

  localparam logic [VW-1:0] EMPTY = '1;
  localparam int NCODE = 1 << VW;

  logic [VW-1:0]    slot_q [TABLE_DEPTH];
  logic [VW-1:0]    map_q  [NTC];
  logic [PW-1:0]    ptr_q, ptr_nxt, len_mask;
  logic [NCODE-1:0] vc_en_pad, vc_pend;
  logic             hit;
  logic [PW-1:0]    hit_idx;
  logic [VW-1:0]    hit_vc;

  assign vc_en_pad = NCODE'(vc_en);

  always_comb begin
    case (tbl_len)
      2'd0:    len_mask = PW'(31);
      2'd1:    len_mask = PW'(63);
      default: len_mask = PW'(TABLE_DEPTH - 1);
    endcase
  end

  always_comb begin
    for (int c = 0; c < NTC; c++)
      map_err[c] = (int'(map_q[c]) >= NUM_VC) || !vc_en_pad[map_q[c]];
  end

  always_comb begin
    vc_pend = '0;
    for (int c = 0; c < NTC; c++)
      if (arb_en && tc_req[c] && !map_err[c]) vc_pend[map_q[c]] = 1'b1;
  end

  always_comb begin
    logic [PW-1:0] idx;
    hit     = 1'b0;
    hit_idx = '0;
    hit_vc  = '0;
    for (int k = 0; k < LOOK; k++) begin
      idx = (ptr_q + PW'(k)) & len_mask;
      if (!hit && vc_pend[slot_q[idx]]) begin
        hit     = 1'b1;
        hit_idx = idx;
        hit_vc  = slot_q[idx];
      end
    end
  end

  always_comb begin
    if (!arb_en)       ptr_nxt = '0;
    else if (~|vc_pend) ptr_nxt = ptr_q;
    else if (hit)      ptr_nxt = (hit_idx + PW'(1)) & len_mask;
    else               ptr_nxt = (ptr_q + PW'(LOOK)) & len_mask;
  end

  assign gnt_vld = hit;

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) gnt_vc[v] = hit && (int'(hit_vc) == v);
    gnt_tc = '0;
    for (int c = 0; c < NTC; c++)
      if (hit && tc_req[c] && !map_err[c] && map_q[c] == hit_vc) gnt_tc = 3'(c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < TABLE_DEPTH; i++) slot_q[i] <= EMPTY;
      for (int c = 0; c < NTC; c++) map_q[c] <= '0;
    end else begin
      ptr_q <= ptr_nxt;
      if (cfg_we && !arb_en) begin
        if (cfg_sel) map_q[cfg_addr[2:0]] <= cfg_data;
        else         slot_q[cfg_addr]     <= cfg_data;
      end
    end
  end

endmodule

// File: rtl/vc_slot_arbiter_chk.sv
module vc_slot_arbiter_chk #(
  parameter int NUM_VC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arb_en,
  input logic [NUM_VC-1:0] vc_en,
  input logic [7:0]        tc_req,
  input logic              gnt_vld,
  input logic [NUM_VC-1:0] gnt_vc,
  input logic [2:0]        gnt_tc,
  input logic [7:0]        map_err
);

  AST_GNT_ONEHOT:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_vc));                 // R8
  AST_VLD_MATCH:      assert property (@(posedge clk) disable iff (!rst_n) gnt_vld == (|gnt_vc));             // R8
  AST_GNT_HAS_REQ:    assert property (@(posedge clk) disable iff (!rst_n) gnt_vld |-> tc_req[gnt_tc]);       // R8
  AST_IDLE_WHEN_OFF:  assert property (@(posedge clk) disable iff (!rst_n) !arb_en |-> !gnt_vld);             // R9
  AST_NO_REQ_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) (tc_req == '0) |-> !gnt_vld);      // R7
  AST_ERR_NEVER_GNT:  assert property (@(posedge clk) disable iff (!rst_n) gnt_vld |-> !map_err[gnt_tc]);     // R10
  AST_GNT_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) gnt_vld |-> |(gnt_vc & vc_en));    // R10

endmodule

bind vc_slot_arbiter vc_slot_arbiter_chk #(.NUM_VC(NUM_VC)) u_chk (.*);

// File: tb/vc_slot_arbiter_bench.sv
`timescale 1ns/1ps
module vc_slot_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arb_en = 1'b0;
  logic [2:0] vc_en = 3'b111;
  logic [1:0] tbl_len = 2'd0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [1:0] cfg_data = '0;
  logic [7:0] tc_req = '0;
  logic       gnt_vld;
  logic [2:0] gnt_vc, gnt_tc;
  logic [7:0] map_err;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vc_slot_arbiter u_vc_slot_arbiter (.*);

  localparam int SCHED [7] = '{2, 1, 1, 2, 0, 0, 0};
  // {expected one-hot channel, expected class} under tc_req = 8'h43
  localparam logic [5:0] VEC [7] = '{6'b100_110, 6'b010_001, 6'b010_001,
                                    6'b100_110, 6'b001_000, 6'b001_000, 6'b001_000};

  task automatic chk(input string rq, input logic ev, input logic [2:0] evc, input logic [2:0] etc_c);
    n_chk++;
    if (gnt_vld !== ev || gnt_vc !== evc || gnt_tc !== etc_c) begin
      n_fail++;
      $display("FAIL %s: got vld=%b vc=%b tc=%0d, expected vld=%b vc=%b tc=%0d",
               rq, gnt_vld, gnt_vc, gnt_tc, ev, evc, etc_c);
    end
  endtask

  task automatic chk_err(input string rq, input logic [7:0] exp);
    n_chk++;
    if (map_err !== exp) begin
      n_fail++;
      $display("FAIL %s: map_err got %b expected %b", rq, map_err, exp);
    end
  endtask

  task automatic step(input logic [7:0] r);
    @(negedge clk);
    tc_req = r;
    #1;
  endtask

  task automatic en(input logic v);
    @(negedge clk);
    tc_req = '0;
    arb_en = v;
  endtask

  task automatic wr(input logic s, input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = 7'(a); cfg_data = 2'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #250000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset idle", 1'b0, 3'b000, 3'd0);
    chk_err("R1 reset map", 8'h00);
    rst_n = 1'b1;

    en(1'b1);
    for (int i = 0; i < 4; i++) begin
      step(8'hFF);
      chk("R1 empty table gives no grant", 1'b0, 3'b000, 3'd0);
    end
    en(1'b0);

    wr(1'b1, 1, 1);
    wr(1'b1, 6, 2);
    for (int i = 0; i < 28; i++) wr(1'b0, i, SCHED[i % 7]);
    en(1'b1);
    for (int i = 0; i < 35; i++) begin
      step(8'h43);
      chk("R5 R3 schedule order and wrap", 1'b1, VEC[i % 7][5:3], VEC[i % 7][2:0]);
    end

    @(negedge clk); arb_en = 1'b0; tc_req = 8'h43; #1;
    chk("R9 disabled gives no grant", 1'b0, 3'b000, 3'd0);
    en(1'b1);
    step(8'h43);
    chk("R9 restart at entry 0", 1'b1, 3'b100, 3'd6);

    en(1'b0); en(1'b1);
    for (int i = 0; i < 6; i++) begin
      step(8'h01);
      chk("R6 skip in same cycle", 1'b1, 3'b001, 3'd0);
    end

    en(1'b0); en(1'b1);
    for (int i = 0; i < 3; i++) begin
      step(8'h00);
      chk("R7 no pending no grant", 1'b0, 3'b000, 3'd0);
    end
    step(8'h43);
    chk("R7 pointer held", 1'b1, 3'b100, 3'd6);

    en(1'b0);
    wr(1'b0, 0, 1);
    for (int i = 1; i < 28; i++) wr(1'b0, i, 3);
    wr(1'b0, 32, 2);
    en(1'b1);
    for (int i = 0; i < 5; i++) begin
      step(8'h42);
      if (i == 0 || i == 4) chk("R6 R4 sparse table len 32", 1'b1, 3'b010, 3'd1);
      else                  chk("R6 window all empty", 1'b0, 3'b000, 3'd0);
    end

    en(1'b0); tbl_len = 2'd1; en(1'b1);
    for (int i = 0; i < 9; i++) begin
      step(8'h42);
      if (i == 0 || i == 8) chk("R4 len 64 entry 0", 1'b1, 3'b010, 3'd1);
      else if (i == 4)      chk("R4 len 64 entry 32", 1'b1, 3'b100, 3'd6);
      else                  chk("R4 len 64 idle", 1'b0, 3'b000, 3'd0);
    end

    en(1'b0); tbl_len = 2'd2; en(1'b1);
    for (int i = 0; i < 17; i++) begin
      step(8'h42);
      if (i == 0 || i == 16) chk("R4 len 128 entry 0", 1'b1, 3'b010, 3'd1);
      else if (i == 4)       chk("R4 len 128 entry 32", 1'b1, 3'b100, 3'd6);
      else if (i == 8)       chk("R4 len 128 no early wrap", 1'b0, 3'b000, 3'd0);
    end

    en(1'b0); tbl_len = 2'd0; en(1'b1);
    wr(1'b0, 0, 2);
    wr(1'b1, 1, 2);
    en(1'b0); en(1'b1);
    step(8'h42);
    chk("R2 writes ignored while enabled", 1'b1, 3'b010, 3'd1);

    en(1'b0);
    vc_en = 3'b011;
    wr(1'b1, 5, 3);
    #1;
    chk_err("R10 error flags", 8'h60);
    en(1'b1);
    for (int i = 0; i < 4; i++) begin
      step(8'h60);
      chk("R10 flagged classes never granted", 1'b0, 3'b000, 3'd0);
    end
    step(8'h62);
    chk("R10 R2 other class still served", 1'b1, 3'b010, 3'd1);

    en(1'b0);
    vc_en = 3'b111;
    wr(1'b1, 3, 1);
    en(1'b1);
    step(8'h0A);
    chk("R11 R8 shared channel highest class", 1'b1, 3'b010, 3'd3);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule